// File: doc/BRIEF.md
# Piecewise-Linear Gaussian Kernel Exponential Evaluator

This block turns a non-negative fixed-point distance into an approximate Gaussian-kernel value. The input range is cut into `2**SEG_W` equal segments, and each segment has its own straight line. The line's slope and intercept sit in two separate coefficient tables. Each sample is scaled by a constant and rounded down to find its segment. Both coefficients of that segment are then read, and the result is the intercept minus the slope times the input.

The block accepts one sample on every clock and has no back-pressure. Every result comes out a fixed number of cycles after its input. The scaling multiplier and the slope multiplier are both modelled as register chains of `MUL_LAT` stages. Two delay lines carry the values that have to wait: the input is held until its slope is available, and the intercept is held until the product is available. Software loads the coefficients through a simple write port while the pipeline is idle. Choosing the coefficient values is outside this block.

Top module: `pwl_exp_eval`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `out_vld` is 0 and `out_y` is 0.
- R2: `out_vld` is `in_vld` delayed by exactly `2*MUL_LAT+3` clocks (19 by default). A new sample is accepted on every cycle, including back-to-back cycles and cycles separated by idle gaps.
- R3: The segment index equals floor(`in_x` * `SCALE` / 2^(2*FRAC_W)). Here `in_x` is unsigned with `FRAC_W` fraction bits, and `SCALE` is unsigned with `FRAC_W` fraction bits. By default `SCALE` is 8.0, so each segment is 1/8 wide and a value exactly on a boundary belongs to the upper segment.
- R4: Any index of `2**SEG_W` or above is clamped to the last segment (63 by default). The product itself still uses the unclamped `in_x`.
- R5: `out_y` = intercept[idx] - ((slope[idx] * `in_x`) >>> `FRAC_W`). Slope and intercept are two's-complement values with `FRAC_W` fraction bits. The shift is arithmetic, and the result is kept modulo 2^`COEF_W`.
- R6: A write with `wr_en`=1 stores `wr_data` at `wr_addr`. `wr_sel`=0 selects the slope table and `wr_sel`=1 selects the intercept table. A write to one table leaves the other table unchanged. The new value is used by every sample accepted after the write.
- R7: When `out_vld` is 0, `out_y` keeps the last valid result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Input sample valid |
| in_x | input | DATA_W | Unsigned distance, FRAC_W fraction bits |
| wr_en | input | 1 | Coefficient write strobe |
| wr_sel | input | 1 | Table select: 0 slope, 1 intercept |
| wr_addr | input | SEG_W | Segment to write |
| wr_data | input | COEF_W | Coefficient value, two's complement |
| out_vld | output | 1 | Result valid |
| out_y | output | COEF_W | Kernel value, two's complement |

## Verification
The assertions check the following on every cycle:
- the fixed valid latency;
- that a clamped or unclamped segment index reaches the address register;
- that the slope lines up with the delayed input at the multiplier;
- that the intercept lines up with the product at the subtractor;
- that the output holds while no result is valid.

The arithmetic can only be shown by the bench's scenarios, which compare each result exactly against a behavioural evaluation of the formula. These scenarios cover segment midpoints, both sides of every segment boundary, inputs far beyond the table, and coefficient rewrites that touch one table only.

// File: rtl/pwl_exp_pkg.sv
package pwl_exp_pkg;

  typedef enum logic {
    TBL_SLOPE = 1'b0,
    TBL_ICPT  = 1'b1
  } tbl_sel_e;

  function automatic int unsigned pwl_latency(int unsigned mul_lat);
    return 2 * mul_lat + 3;
  endfunction

endpackage

// File: rtl/pwl_delay.sv
module pwl_delay #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_vld,
  input  logic [W-1:0] in_data,
  output logic         out_vld,
  output logic [W-1:0] out_data
);

  logic [DEPTH-1:0] vld_q, vld_d;
  logic [W-1:0]     dat_q [DEPTH];
  logic [W-1:0]     dat_d [DEPTH];

  always_comb begin
    vld_d[0] = in_vld;
    dat_d[0] = in_data;
    for (int i = 1; i < DEPTH; i++) begin
      vld_d[i] = vld_q[i-1];
      dat_d[i] = dat_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  // data stages load only when a valid token enters them
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (vld_d[i]) dat_q[i] <= dat_d[i];
    end
  end

  assign out_vld  = vld_q[DEPTH-1];
  assign out_data = dat_q[DEPTH-1];

endmodule

// File: rtl/pwl_mul_pipe.sv
module pwl_mul_pipe #(
  parameter int unsigned A_W = 8,
  parameter int unsigned B_W = 8,
  parameter int unsigned LAT = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_vld,
  input  logic signed [A_W-1:0]     a,
  input  logic signed [B_W-1:0]     b,
  output logic                      out_vld,
  output logic signed [A_W+B_W-1:0] p
);

  localparam int unsigned PW = A_W + B_W;

  logic signed [PW-1:0] a_ext, b_ext, p_comb;
  logic [PW-1:0]        p_dly;

  assign a_ext  = PW'(a);
  assign b_ext  = PW'(b);
  assign p_comb = a_ext * b_ext;

  pwl_delay #(.W(PW), .DEPTH(LAT)) u_stages (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (in_vld),
    .in_data (p_comb),
    .out_vld (out_vld),
    .out_data(p_dly)
  );

  assign p = p_dly;

endmodule

// File: rtl/pwl_coef_table.sv
module pwl_coef_table
  import pwl_exp_pkg::*;
#(
  parameter int unsigned SEG_W  = 6,
  parameter int unsigned COEF_W = 24
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [SEG_W-1:0]  wr_addr,
  input  logic [COEF_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [SEG_W-1:0]  rd_addr,
  output logic [COEF_W-1:0] rd_slope,
  output logic [COEF_W-1:0] rd_icpt
);

  localparam int unsigned NSEG = 1 << SEG_W;

  logic [COEF_W-1:0] rd_q [2];

  for (genvar g = 0; g < 2; g++) begin : g_tbl
    logic [COEF_W-1:0] mem [NSEG];
    logic              we;

    assign we = wr_en && (tbl_sel_e'(wr_sel) == tbl_sel_e'(g));

    always_ff @(posedge clk) begin
      if (we)    mem[wr_addr] <= wr_data;
      if (rd_en) rd_q[g]      <= mem[rd_addr];
    end
  end

  assign rd_slope = rd_q[TBL_SLOPE];
  assign rd_icpt  = rd_q[TBL_ICPT];

endmodule

// File: rtl/pwl_exp_eval.sv
module pwl_exp_eval #(
  parameter int unsigned DATA_W  = 24,
  parameter int unsigned FRAC_W  = 16,
  parameter int unsigned COEF_W  = 24,
  parameter int unsigned SEG_W   = 6,
  parameter int unsigned MUL_LAT = 8,
  parameter int unsigned SCALE_W = 24,
  parameter int unsigned SCALE   = 524288
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_x,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [SEG_W-1:0]  wr_addr,
  input  logic [COEF_W-1:0] wr_data,
  output logic              out_vld,
  output logic [COEF_W-1:0] out_y
);

  localparam int unsigned NSEG  = 1 << SEG_W;
  localparam int unsigned SP_W  = DATA_W + SCALE_W + 2;
  localparam int unsigned IDX_W = SP_W - 2 * FRAC_W;
  localparam int unsigned PR_W  = COEF_W + DATA_W + 1;

  // scale path
  logic              s_vld;
  logic [SP_W-1:0]   s_prod;
  logic [IDX_W-1:0]  idx_full;
  logic [SEG_W-1:0]  seg_d, seg_q;
  logic              seg_vld_q;

  // table read
  logic [COEF_W-1:0] k_rd, b_rd;
  logic              rd_vld_q;

  // aligned operands
  logic              xd_vld;
  logic [DATA_W-1:0] xd;
  logic              pr_vld;
  logic [PR_W-1:0]   pr;
  logic              bd_vld;
  logic [COEF_W-1:0] bd;

  // output
  logic [COEF_W-1:0] y_d;
  logic              out_vld_q;
  logic [COEF_W-1:0] out_y_q;

  pwl_mul_pipe #(.A_W(DATA_W + 1), .B_W(SCALE_W + 1), .LAT(MUL_LAT)) u_scale (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_vld (in_vld),
    .a      ({1'b0, in_x}),
    .b      ({1'b0, SCALE_W'(SCALE)}),
    .out_vld(s_vld),
    .p      (s_prod)
  );

  // segment index: integer part of the scaled value, clamped to the table
  always_comb begin
    idx_full = s_prod[SP_W-1:2*FRAC_W];
    if (idx_full > IDX_W'(NSEG - 1)) seg_d = SEG_W'(NSEG - 1);
    else                             seg_d = idx_full[SEG_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_vld_q <= 1'b0;
      rd_vld_q  <= 1'b0;
    end else begin
      seg_vld_q <= s_vld;
      rd_vld_q  <= seg_vld_q;
    end
  end

  always_ff @(posedge clk) begin
    if (s_vld) seg_q <= seg_d;
  end

  pwl_coef_table #(.SEG_W(SEG_W), .COEF_W(COEF_W)) u_tbl (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_en   (seg_vld_q),
    .rd_addr (seg_q),
    .rd_slope(k_rd),
    .rd_icpt (b_rd)
  );

  // input waits for scaling, index register and table read
  pwl_delay #(.W(DATA_W), .DEPTH(MUL_LAT + 2)) u_xdly (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (in_vld),
    .in_data (in_x),
    .out_vld (xd_vld),
    .out_data(xd)
  );

  pwl_mul_pipe #(.A_W(COEF_W), .B_W(DATA_W + 1), .LAT(MUL_LAT)) u_prod (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_vld (rd_vld_q),
    .a      (k_rd),
    .b      ({1'b0, xd}),
    .out_vld(pr_vld),
    .p      (pr)
  );

  // intercept waits for the product
  pwl_delay #(.W(COEF_W), .DEPTH(MUL_LAT)) u_bdly (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (rd_vld_q),
    .in_data (b_rd),
    .out_vld (bd_vld),
    .out_data(bd)
  );

  assign y_d = bd - pr[FRAC_W +: COEF_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld_q <= 1'b0;
      out_y_q   <= '0;
    end else begin
      out_vld_q <= pr_vld;
      if (pr_vld) out_y_q <= y_d;
    end
  end

  assign out_vld = out_vld_q;
  assign out_y   = out_y_q;

  logic unused_bits;
  assign unused_bits = ^{s_prod[2*FRAC_W-1:0], pr[PR_W-1:FRAC_W+COEF_W],
                         pr[FRAC_W-1:0], xd_vld, bd_vld};

endmodule

// File: rtl/pwl_exp_eval_chk.sv
module pwl_exp_eval_chk #(
  parameter int unsigned SEG_W   = 6,
  parameter int unsigned COEF_W  = 24,
  parameter int unsigned MUL_LAT = 8,
  parameter int unsigned IDX_W   = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_vld,
  input logic              out_vld,
  input logic [COEF_W-1:0] out_y,
  input logic              s_vld,
  input logic [IDX_W-1:0]  idx_full,
  input logic [SEG_W-1:0]  seg_q,
  input logic              rd_vld_q,
  input logic              xd_vld,
  input logic              pr_vld,
  input logic              bd_vld
);

  localparam int unsigned LAT  = pwl_exp_pkg::pwl_latency(MUL_LAT);
  localparam int unsigned NSEG = 1 << SEG_W;

  logic [LAT-1:0] vld_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_sh <= '0;
    else        vld_sh <= {vld_sh[LAT-2:0], in_vld};
  end

  AST_OUT_VLD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld == vld_sh[LAT-1]); // R2

  AST_SEG_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (s_vld && (idx_full > IDX_W'(NSEG - 1))) |=> (seg_q == SEG_W'(NSEG - 1))); // R4

  AST_SEG_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (s_vld && (idx_full <= IDX_W'(NSEG - 1))) |=> (seg_q == $past(idx_full[SEG_W-1:0]))); // R3

  AST_SLOPE_X_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld_q == xd_vld); // R5

  AST_ICPT_PROD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    pr_vld == bd_vld); // R5

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> $stable(out_y)); // R7

endmodule

bind pwl_exp_eval pwl_exp_eval_chk #(
  .SEG_W  (SEG_W),
  .COEF_W (COEF_W),
  .MUL_LAT(MUL_LAT),
  .IDX_W  (IDX_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_vld  (in_vld),
  .out_vld (out_vld),
  .out_y   (out_y),
  .s_vld   (s_vld),
  .idx_full(idx_full),
  .seg_q   (seg_q),
  .rd_vld_q(rd_vld_q),
  .xd_vld  (xd_vld),
  .pr_vld  (pr_vld),
  .bd_vld  (bd_vld)
);

// File: tb/pwl_exp_eval_tb.sv
module pwl_exp_eval_tb;

  localparam int DATA_W  = 24;
  localparam int FRAC_W  = 16;
  localparam int COEF_W  = 24;
  localparam int SEG_W   = 6;
  localparam int MUL_LAT = 8;
  localparam int SCALE   = 524288;
  localparam int LAT     = 2 * MUL_LAT + 3;
  localparam int NSEG    = 64;
  localparam int SEGLEN  = 8192;

  logic              clk;
  logic              rst_n;
  logic              in_vld;
  logic [DATA_W-1:0] in_x;
  logic              wr_en;
  logic              wr_sel;
  logic [SEG_W-1:0]  wr_addr;
  logic [COEF_W-1:0] wr_data;
  logic              out_vld;
  logic [COEF_W-1:0] out_y;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  int mk [NSEG];
  int mb [NSEG];

  bit               q_vld [$];
  logic [COEF_W-1:0] q_dat [$];
  string            q_tag [$];
  logic [COEF_W-1:0] last_y;

  pwl_exp_eval u_dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_vld (in_vld),
    .in_x   (in_x),
    .wr_en  (wr_en),
    .wr_sel (wr_sel),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .out_vld(out_vld),
    .out_y  (out_y)
  );

  initial clk = 1'b0;
  always #10ns clk = ~clk;

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [COEF_W-1:0] ref_y(longint x);
    longint sc, idx, p, y;
    sc  = x * SCALE;
    idx = sc >> (2 * FRAC_W);
    if (idx > NSEG - 1) idx = NSEG - 1;
    p = longint'(mk[idx]) * x;
    p = p >>> FRAC_W;
    y = longint'(mb[idx]) - p;
    return y[COEF_W-1:0];
  endfunction

  // compare the current outputs with the entry pushed LAT cycles ago
  task automatic compare_out();
    bit               ev;
    logic [COEF_W-1:0] ed;
    string            et;
    ev = q_vld.pop_front();
    ed = q_dat.pop_front();
    et = q_tag.pop_front();
    check("R2 valid", longint'(out_vld), longint'(ev));
    if (ev) begin
      last_y = ed;
      check(et, longint'(out_y), longint'(ed));
    end else begin
      check("R7 hold", longint'(out_y), longint'(last_y));
    end
  endtask

  task automatic cycle(bit v, longint x, string tag);
    @(negedge clk);
    compare_out();
    wr_en  = 1'b0;
    in_vld = v;
    in_x   = x[DATA_W-1:0];
    q_vld.push_back(v);
    q_dat.push_back(v ? ref_y(x) : '0);
    q_tag.push_back(tag);
  endtask

  task automatic write(bit sel, int addr, int val);
    @(negedge clk);
    compare_out();
    in_vld  = 1'b0;
    wr_en   = 1'b1;
    wr_sel  = sel;
    wr_addr = addr[SEG_W-1:0];
    wr_data = val[COEF_W-1:0];
    if (sel) mb[addr] = val;
    else     mk[addr] = val;
    q_vld.push_back(1'b0);
    q_dat.push_back('0);
    q_tag.push_back("R7 hold");
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cycle(1'b0, 0, "R7 hold");
  endtask

  initial begin
    #(20ns * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n   = 1'b0;
    in_vld  = 1'b0;
    in_x    = '0;
    wr_en   = 1'b0;
    wr_sel  = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    last_y  = '0;
    for (int i = 0; i < LAT; i++) begin
      q_vld.push_back(1'b0);
      q_dat.push_back('0);
      q_tag.push_back("R7 hold");
    end
    repeat (3) @(negedge clk);
    check("R1 out_vld in reset", longint'(out_vld), 0);
    check("R1 out_y in reset", longint'(out_y), 0);
    rst_n = 1'b1;
    @(posedge clk);
    #1ns;
    check("R1 out_vld after release", longint'(out_vld), 0);
    check("R1 out_y after release", longint'(out_y), 0);

    // R6: load both tables, including negative slopes
    for (int i = 0; i < NSEG; i++) begin
      mk[i] = (i % 9 == 4) ? -(3000 + 50 * i) : (60000 - 800 * i);
      mb[i] = 65536 - 1000 * i;
      write(1'b0, i, mk[i]);
      write(1'b1, i, mb[i]);
    end
    idle(3);

    // R3: midpoints of every segment, back to back
    for (int i = 0; i < NSEG; i++) cycle(1'b1, i * SEGLEN + SEGLEN / 2, "R3 midpoint");
    // R3: both sides of every internal boundary
    for (int i = 1; i < NSEG; i++) begin
      cycle(1'b1, i * SEGLEN, "R3 boundary upper");
      cycle(1'b1, i * SEGLEN - 1, "R3 boundary lower");
    end
    // R4: beyond the last segment
    cycle(1'b1, NSEG * SEGLEN, "R4 clamp edge");
    cycle(1'b1, 600000, "R4 clamp");
    cycle(1'b1, 3000000, "R4 clamp far");
    cycle(1'b1, (1 << DATA_W) - 1, "R4 clamp max");
    cycle(1'b1, 0, "R5 zero input");
    // R2 / R5: gapped stream
    for (int i = 0; i < 60; i++)
      cycle(i % 3 != 0, (i * 12345) % (NSEG * SEGLEN), "R5 gapped");
    idle(LAT + 2);

    // R6: rewrite one segment, intercept only on its neighbour
    write(1'b0, 5, -20000);
    write(1'b1, 5, 12345);
    write(1'b1, 6, 999);
    idle(2);
    cycle(1'b1, 5 * SEGLEN + 100, "R6 new slope and intercept");
    cycle(1'b1, 6 * SEGLEN + 100, "R6 intercept only, slope kept");
    cycle(1'b1, 7 * SEGLEN + 100, "R6 untouched segment");
    idle(LAT + 4);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule